// File: doc/BRIEF.md
# Immediate-Load and Add Sequencer

This block steps through a byte-wide code memory from a fixed start pointer and runs a tiny instruction set. Three forms are recognised: load a 16-bit immediate into the accumulator, load a 16-bit immediate into an auxiliary register, and add the auxiliary register into the accumulator. Instructions have different lengths. The block fetches one byte per clock at `ip_o` plus an offset, and the code memory returns that byte combinationally on `code_data_i`.

After each instruction completes, the instruction pointer moves to the first byte of the next instruction. The add sets a carry flag and a zero flag. Any other encoding stops the block. It then holds every register and asserts `halt_o` until reset. The register contents and the pointer appear on debug outputs.

Top module: `imm_add_seq`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `ip_o` is 0x0100, `acc_o` and `aux_o` are 0, and `carry_o`, `zero_o` and `halt_o` are 0.
- R2: Opcode 0xB8 followed by two bytes L, H loads the accumulator with {H, L}. The first immediate byte goes to the low half and the second to the high half. The new value appears after the 4th rising edge counted from the opcode fetch.
- R3: Opcode 0xBB followed by L, H loads the auxiliary register with {H, L} using the same 4-cycle timing. The accumulator is not changed.
- R4: The byte pair 0x01, 0xD8 replaces the accumulator with (accumulator + auxiliary) mod 2^16. The result appears after the 3rd rising edge counted from the opcode fetch.
- R5: `code_addr_o` equals `ip_o` during the opcode fetch, `ip_o`+1 during the first operand fetch and `ip_o`+2 during the second. When an instruction completes, `ip_o` advances by its length: 3 for loads and 2 for the add.
- R6: The add sets `carry_o` to the carry out of bit 15 and sets `zero_o` when the 16-bit result is 0. Loads leave both flags unchanged.
- R7: An opcode other than 0xB8, 0xBB or 0x01, or a 0x01 followed by any byte other than 0xD8, sets `halt_o` on the edge that samples the bad byte. From then until reset, `ip_o` (still pointing at the offending instruction), both registers and both flags stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; restarts execution at 0x0100 |
| code_addr_o | output | 16 | Byte address into code memory |
| code_data_i | input | 8 | Code byte at `code_addr_o`, valid in the same cycle |
| acc_o | output | 16 | Accumulator contents |
| aux_o | output | 16 | Auxiliary register contents |
| ip_o | output | 16 | Start address of the current instruction |
| carry_o | output | 1 | Carry out of the last add |
| zero_o | output | 1 | Last add result was zero |
| halt_o | output | 1 | Unrecognised encoding seen; held until reset |

## Verification
The assertions rely on the code memory answering within the same cycle, so that `code_data_i` always belongs to the address being driven. They also assume that `ip_o` never wraps past 0xFFFF within a run. The bench models the code memory as a combinational array that holds 0xFF everywhere except where a program is placed. Every program sits well below the wrap point and ends on an unknown opcode, so each run finishes in the halt state at a known pointer.

// File: rtl/imm_add_seq_pkg.sv
package imm_add_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int NB     = REG_W / BYTE_W;

  localparam logic [BYTE_W-1:0] OP_LD_ACC = 8'hB8;
  localparam logic [BYTE_W-1:0] OP_LD_AUX = 8'hBB;
  localparam logic [BYTE_W-1:0] OP_ADD    = 8'h01;
  localparam logic [BYTE_W-1:0] ADD_SEL   = 8'hD8;

  typedef enum logic [1:0] {ST_OP, ST_B1, ST_B2, ST_EX} seq_state_e;
  typedef enum logic [1:0] {K_LDA, K_LDB, K_ADD, K_BAD} ins_kind_e;
endpackage

// File: rtl/imm_add_seq_dec.sv
module imm_add_seq_dec
  import imm_add_seq_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output ins_kind_e         kind_o,
  output logic [1:0]        len_o
);
  always_comb begin
    unique case (op_i)
      OP_LD_ACC: begin kind_o = K_LDA; len_o = 2'd3; end
      OP_LD_AUX: begin kind_o = K_LDB; len_o = 2'd3; end
      OP_ADD:    begin kind_o = K_ADD; len_o = 2'd2; end
      default:   begin kind_o = K_BAD; len_o = 2'd0; end
    endcase
  end
endmodule

// File: rtl/imm_add_seq_breg.sv
module imm_add_seq_breg #(
  parameter int BW = 8,
  parameter int N  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  we_i,
  input  logic [BW*N-1:0] d_i,
  output logic [BW*N-1:0] q_o
);
  logic [BW-1:0] byte_q [N];

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q[g] <= '0;
      else if (we_i[g]) byte_q[g] <= d_i[g*BW +: BW];
    end
    assign q_o[g*BW +: BW] = byte_q[g];
  end
endmodule

// File: rtl/imm_add_seq_add.sv
module imm_add_seq_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         zero_o
);
  assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
  assign zero_o = (sum_o == '0);
endmodule

// File: rtl/imm_add_seq.sv
module imm_add_seq
  import imm_add_seq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_IP = 'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [AW-1:0]     code_addr_o,
  input  logic [BYTE_W-1:0] code_data_i,
  output logic [REG_W-1:0]  acc_o,
  output logic [REG_W-1:0]  aux_o,
  output logic [AW-1:0]     ip_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              halt_o
);
  seq_state_e        state_q;
  ins_kind_e         kind_q, dec_kind;
  logic [1:0]        len_q, dec_len, fetch_off;
  logic [AW-1:0]     ip_q;
  logic [BYTE_W-1:0] b1_q, b2_q;
  logic              halt_q, carry_q, zero_q;
  logic              exec;
  logic [NB-1:0]     acc_we, aux_we;
  logic [REG_W-1:0]  acc_d, imm, sum;
  logic              sum_c, sum_z;

  imm_add_seq_dec u_dec (
    .op_i   (code_data_i),
    .kind_o (dec_kind),
    .len_o  (dec_len)
  );

  imm_add_seq_add #(.W(REG_W)) u_add (
    .a_i     (acc_o),
    .b_i     (aux_o),
    .sum_o   (sum),
    .carry_o (sum_c),
    .zero_o  (sum_z)
  );

  always_comb begin
    unique case (state_q)
      ST_B1:   fetch_off = 2'd1;
      ST_B2:   fetch_off = 2'd2;
      default: fetch_off = 2'd0;
    endcase
  end
  assign code_addr_o = ip_q + AW'(fetch_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OP;
      kind_q  <= K_BAD;
      len_q   <= '0;
      ip_q    <= RESET_IP;
      b1_q    <= '0;
      b2_q    <= '0;
      halt_q  <= 1'b0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (!halt_q) begin
      unique case (state_q)
        ST_OP: begin
          kind_q <= dec_kind;
          len_q  <= dec_len;
          if (dec_kind == K_BAD) halt_q  <= 1'b1;
          else                   state_q <= ST_B1;
        end
        ST_B1: begin
          b1_q <= code_data_i;
          if (kind_q == K_ADD) begin
            // two-byte add: second byte must select the aux-to-acc form
            if (code_data_i == ADD_SEL) state_q <= ST_EX;
            else                        halt_q  <= 1'b1;
          end else begin
            state_q <= ST_B2;
          end
        end
        ST_B2: begin
          b2_q    <= code_data_i;
          state_q <= ST_EX;
        end
        ST_EX: begin
          ip_q    <= ip_q + AW'(len_q);
          state_q <= ST_OP;
          if (kind_q == K_ADD) begin
            carry_q <= sum_c;
            zero_q  <= sum_z;
          end
        end
        default: state_q <= ST_OP;
      endcase
    end
  end

  assign exec   = (state_q == ST_EX) && !halt_q;
  assign imm    = {b2_q, b1_q};  // little-endian immediate
  assign acc_we = {NB{exec && (kind_q == K_LDA || kind_q == K_ADD)}};
  assign aux_we = {NB{exec && (kind_q == K_LDB)}};
  assign acc_d  = (kind_q == K_ADD) ? sum : imm;

  imm_add_seq_breg #(.BW(BYTE_W), .N(NB)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (acc_we),
    .d_i    (acc_d),
    .q_o    (acc_o)
  );

  imm_add_seq_breg #(.BW(BYTE_W), .N(NB)) u_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (aux_we),
    .d_i    (imm),
    .q_o    (aux_o)
  );

  assign ip_o    = ip_q;
  assign carry_o = carry_q;
  assign zero_o  = zero_q;
  assign halt_o  = halt_q;
endmodule

// File: rtl/imm_add_seq_chk.sv
module imm_add_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] code_addr_o,
  input logic [15:0]   acc_o,
  input logic [15:0]   aux_o,
  input logic [AW-1:0] ip_o,
  input logic          carry_o,
  input logic          zero_o,
  input logic          halt_o
);
  a_r7_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(ip_o) && $stable(acc_o) && $stable(aux_o)
                && $stable({carry_o, zero_o})));

  a_r5_ip_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ip_o) |-> (ip_o == $past(ip_o) + AW'(3) || ip_o == $past(ip_o) + AW'(2)));

  a_r5_fetch_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_addr_o - ip_o) <= AW'(2));

  a_r6_flags_on_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({carry_o, zero_o}) |-> (ip_o == $past(ip_o) + AW'(2)));

  a_r6_zero_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip_o == $past(ip_o) + AW'(2)) |-> (zero_o == (acc_o == 16'h0000)));
endmodule

bind imm_add_seq imm_add_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_imm_add_seq.sv
`timescale 1ns/1ps
module test_imm_add_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr, acc, aux, ip;
  logic [7:0]  data;
  logic        carry, zero, halt;
  logic [7:0]  mem [0:511];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign data = mem[addr[8:0]];

  imm_add_seq i_imm_add_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .code_addr_o (addr),
    .code_data_i (data),
    .acc_o       (acc),
    .aux_o       (aux),
    .ip_o        (ip),
    .carry_o     (carry),
    .zero_o      (zero),
    .halt_o      (halt)
  );

  // {acc immediate, aux immediate}
  localparam logic [31:0] VEC [6] = '{
    32'h0005_000A, 32'hFFFF_0001, 32'h8000_8000,
    32'h1234_0000, 32'h00FF_0001, 32'h7FFF_0001
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    foreach (mem[i]) mem[i] = 8'hFF;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] s;
    clear_mem();
    do_reset();
    chk("R1 ip", ip, 16'h0100);
    chk("R1 acc", acc, 0);
    chk("R1 aux", aux, 0);
    chk("R1 flags/halt", {carry, zero, halt}, 0);

    // table: load, load, add, then unknown opcode
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a, b;
      a = VEC[i][31:16];
      b = VEC[i][15:0];
      clear_mem();
      put(256, 8'hB8); put(257, a[7:0]); put(258, a[15:8]);
      put(259, 8'hBB); put(260, b[7:0]); put(261, b[15:8]);
      put(262, 8'h01); put(263, 8'hD8);
      do_reset();
      step(12);
      s = {1'b0, a} + {1'b0, b};
      chk("R4 sum", acc, s[15:0]);
      chk("R3 aux", aux, b);
      chk("R6 carry", carry, s[16]);
      chk("R6 zero", zero, (s[15:0] == 16'h0));
      chk("R5 ip end", ip, 16'h0108);
      chk("R7 halt", halt, 1);
    end

    // directed: 5 + 10 + 15 with cycle timing
    clear_mem();
    put(256, 8'hB8); put(257, 8'h05); put(258, 8'h00);
    put(259, 8'hBB); put(260, 8'h0A); put(261, 8'h00);
    put(262, 8'h01); put(263, 8'hD8);
    put(264, 8'hBB); put(265, 8'h0F); put(266, 8'h00);
    put(267, 8'h01); put(268, 8'hD8);
    do_reset();
    chk("R5 opcode addr", addr, 16'h0100);
    step(1);
    chk("R5 operand addr", addr, 16'h0101);
    step(1);
    chk("R5 second operand addr", addr, 16'h0102);
    step(1);
    chk("R2 not yet written", acc, 0);
    step(1);
    chk("R2 acc load", acc, 16'h0005);
    chk("R5 ip +3", ip, 16'h0103);
    step(4);
    chk("R3 aux load", aux, 16'h000A);
    chk("R3 acc kept", acc, 16'h0005);
    step(3);
    chk("R4 first add", acc, 16'h000F);
    chk("R5 ip +2", ip, 16'h0108);
    step(7);
    chk("R4 total", acc, 16'h001E);
    chk("R6 flags", {carry, zero}, 0);
    chk("R5 ip last", ip, 16'h010D);
    chk("R7 not halted yet", halt, 0);
    step(1);
    chk("R7 halt", halt, 1);
    step(5);
    chk("R7 frozen ip", ip, 16'h010D);
    chk("R7 frozen acc", acc, 16'h001E);
    chk("R7 frozen aux", aux, 16'h000F);

    // loads leave flags; byte order of immediate
    clear_mem();
    put(256, 8'hB8); put(257, 8'hFF); put(258, 8'hFF);
    put(259, 8'hBB); put(260, 8'h01); put(261, 8'h00);
    put(262, 8'h01); put(263, 8'hD8);
    put(264, 8'hB8); put(265, 8'h34); put(266, 8'h12);
    do_reset();
    step(11);
    chk("R6 wrap carry", carry, 1);
    chk("R6 wrap zero", zero, 1);
    step(4);
    chk("R2 little-endian", acc, 16'h1234);
    chk("R6 load keeps flags", {carry, zero}, 2'b11);

    // 0x01 with wrong second byte
    clear_mem();
    put(256, 8'h01); put(257, 8'h00);
    do_reset();
    step(1);
    chk("R7 no early halt", halt, 0);
    step(1);
    chk("R7 bad add form", halt, 1);
    chk("R7 ip at bad insn", ip, 16'h0100);
    chk("R7 acc untouched", acc, 0);
    do_reset();
    chk("R1 reset clears halt", halt, 0);

    // unknown first opcode
    clear_mem();
    put(256, 8'h90);
    do_reset();
    step(1);
    chk("R7 unknown opcode", halt, 1);
    step(3);
    chk("R7 ip held", ip, 16'h0100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule